// File: doc/BRIEF.md
# GPIO Pin Register Block

This block is a 32-bit general-purpose I/O register file that sits on a simple word-addressed register bus. It keeps three pieces of state: the driven pin levels, a per-pin direction mask (1 = output) and a free auxiliary word. Software reads the levels, direction and auxiliary word at fixed offsets. It can write the direction and auxiliary words directly. Pin levels, however, can only be changed through two dedicated write offsets, one that sets bits and one that clears them.

A set or clear write is gated by the direction mask as a whole, not bit by bit. When the written value shares at least one bit with the output-direction mask, the entire value is applied, including bits that point at input pins. When it shares none, the write is dropped and a one-cycle bad-access flag is raised. Offsets reserved for edge-detect configuration accept writes and discard them. Writes to any offset the block does not know also raise the flag. Nine interrupt lines are present for system wiring and are held low.

Top module: `gpio_regblk`

## Requirements
- R1: While reset is asserted, and after it, the level, direction and auxiliary words are zero, and `bus_rvld`, `bus_rdata` and `bad_access` are zero.
- R2: A write to byte offset 0x04 loads the direction word and a write to 0x20 loads the auxiliary word. A later read of the same offset returns the written value.
- R3: A read request (`bus_vld`=1, `bus_wr`=0) returns its data on `bus_rdata` with `bus_rvld`=1 in the cycle after the request. `bus_rvld` is 0 after any cycle without a read request. A read at offset 0x00 returns the level word.
- R4: A write to offset 0x08 whose value ANDed with the direction word is nonzero ORs the whole written value into the level word, including bits whose direction bit is 0.
- R5: A write to offset 0x0C whose value ANDed with the direction word is nonzero clears every written bit in the level word, including bits whose direction bit is 0.
- R6: A write to offset 0x08 or 0x0C whose value ANDed with the direction word is zero leaves the level word unchanged. It raises `bad_access` for exactly the following cycle.
- R7: Writes to offsets 0x10, 0x14 and 0x18 change no state and do not raise `bad_access`.
- R8: A read of any offset other than 0x00, 0x04 and 0x20 returns zero.
- R9: A write to any other offset, including any address whose two low bits are nonzero, changes no state. It raises `bad_access` for the following cycle.
- R10: A write to the direction word leaves the level word unchanged. The level word changes only through accepted writes at 0x08 or 0x0C.
- R11: All nine bits of `irq_lines` are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_vld | input | 1 | Bus request valid for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address of the 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvld | output | 1 | Read data valid, one cycle after a read request |
| bad_access | output | 1 | One-cycle pulse for an undecoded write or a rejected set/clear |
| pin_level | output | 32 | Current level word driven towards the pads |
| pin_dir | output | 32 | Current direction word (1 = output) |
| irq_lines | output | 9 | Interrupt outputs, held low |

## Verification
The assertions assume that the bus stays idle from reset release until the internal reset synchroniser has let go, two clock cycles later. During that time a request is neither served nor flagged, so a property stating what a write must do would be contradicted. The bench therefore waits four cycles after releasing reset before issuing any request, both at start-up and after the mid-run reset. The assertions also assume that every request holds its address and data for exactly one clock cycle. The bench drives each request on a falling edge and removes it on the next falling edge.

// File: rtl/gpio_regblk_pkg.sv
package gpio_regblk_pkg;

  // Byte offsets of the decoded words
  localparam logic [7:0] OFF_LEVEL = 8'h00;
  localparam logic [7:0] OFF_DIR   = 8'h04;
  localparam logic [7:0] OFF_SET   = 8'h08;
  localparam logic [7:0] OFF_CLR   = 8'h0C;
  localparam logic [7:0] OFF_RISE  = 8'h10;
  localparam logic [7:0] OFF_FALL  = 8'h14;
  localparam logic [7:0] OFF_EVT   = 8'h18;
  localparam logic [7:0] OFF_AUX   = 8'h20;

  localparam int N_SLOTS = 8;

  // Slot index of each decoded offset in the hit vector
  typedef enum logic [2:0] {
    SLOT_LEVEL = 3'd0,
    SLOT_DIR   = 3'd1,
    SLOT_SET   = 3'd2,
    SLOT_CLR   = 3'd3,
    SLOT_RISE  = 3'd4,
    SLOT_FALL  = 3'd5,
    SLOT_EVT   = 3'd6,
    SLOT_AUX   = 3'd7
  } slot_e;

  localparam logic [7:0] SLOT_OFFS [N_SLOTS] = '{
    OFF_LEVEL, OFF_DIR, OFF_SET, OFF_CLR,
    OFF_RISE, OFF_FALL, OFF_EVT, OFF_AUX
  };

  // Decoded target of the current bus address
  typedef struct packed {
    logic level;
    logic dir;
    logic set;
    logic clr;
    logic edge_cfg;
    logic aux;
    logic known;
  } sel_t;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_regblk_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel
);

  localparam int SLOT_BITS = 8;

  logic [N_SLOTS-1:0] hit;

  // One comparator per decoded slot; low two bits must be zero (word access)
  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    logic [SLOT_BITS-1:0] ext_addr;
    always_comb begin
      ext_addr = '0;
      ext_addr[ADDR_W-1:0] = addr;
      hit[i] = (ext_addr == SLOT_OFFS[i]);
    end
  end

  always_comb begin
    sel          = '0;
    sel.level    = hit[SLOT_LEVEL];
    sel.dir      = hit[SLOT_DIR];
    sel.set      = hit[SLOT_SET];
    sel.clr      = hit[SLOT_CLR];
    sel.edge_cfg = hit[SLOT_RISE] | hit[SLOT_FALL] | hit[SLOT_EVT];
    sel.aux      = hit[SLOT_AUX];
    sel.known    = |hit;
  end

endmodule

// File: rtl/gpio_core_regs.sv
module gpio_core_regs
  import gpio_regblk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  sel_t              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] level,
  output logic [DATA_W-1:0] dir,
  output logic [DATA_W-1:0] aux,
  output logic              reject
);

  logic [DATA_W-1:0] level_q, level_d;
  logic [DATA_W-1:0] dir_q,   dir_d;
  logic [DATA_W-1:0] aux_q,   aux_d;
  logic              level_en, dir_en, aux_en;
  logic              drives_output;
  logic              pin_op;

  // Whole-word gate: any overlap with an output bit admits the full value
  always_comb begin
    drives_output = |(wdata & dir_q);
    pin_op        = wr_en & (sel.set | sel.clr);
    reject        = pin_op & ~drives_output;
  end

  always_comb begin
    level_en = pin_op & drives_output;
    dir_en   = wr_en & sel.dir;
    aux_en   = wr_en & sel.aux;

    level_d = level_q;
    if (sel.set) begin
      level_d = level_q | wdata;
    end else if (sel.clr) begin
      level_d = level_q & ~wdata;
    end
    dir_d = wdata;
    aux_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
    end else if (level_en) begin
      level_q <= level_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (dir_en) begin
      dir_q <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_q <= '0;
    end else if (aux_en) begin
      aux_q <= aux_d;
    end
  end

  assign level = level_q;
  assign dir   = dir_q;
  assign aux   = aux_q;

endmodule

// File: rtl/gpio_rd_port.sv
module gpio_rd_port
  import gpio_regblk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  sel_t              sel,
  input  logic [DATA_W-1:0] level,
  input  logic [DATA_W-1:0] dir,
  input  logic [DATA_W-1:0] aux,
  output logic [DATA_W-1:0] rdata,
  output logic              rvld
);

  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvld_q, rvld_d;

  always_comb begin
    rdata_d = '0;
    unique case (1'b1)
      sel.level: rdata_d = level;
      sel.dir:   rdata_d = dir;
      sel.aux:   rdata_d = aux;
      default:   rdata_d = '0;
    endcase
    rvld_d = rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvld_q <= 1'b0;
    end else begin
      rvld_q <= rvld_d;
    end
  end

  assign rdata = rdata_q;
  assign rvld  = rvld_q;

endmodule

// File: rtl/gpio_regblk.sv
module gpio_regblk
  import gpio_regblk_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 32,
  parameter int N_IRQ       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_vld,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvld,
  output logic              bad_access,
  output logic [DATA_W-1:0] pin_level,
  output logic [DATA_W-1:0] pin_dir,
  output logic [N_IRQ-1:0]  irq_lines
);

  logic              rst_n_int;
  sel_t              sel;
  logic              wr_en, rd_en;
  logic              reject;
  logic [DATA_W-1:0] aux_word;
  logic              bad_d, bad_q;

  gpio_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  always_comb begin
    wr_en = bus_vld &  bus_wr;
    rd_en = bus_vld & ~bus_wr;
  end

  gpio_core_regs #(.DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .wr_en  (wr_en),
    .sel    (sel),
    .wdata  (bus_wdata),
    .level  (pin_level),
    .dir    (pin_dir),
    .aux    (aux_word),
    .reject (reject)
  );

  gpio_rd_port #(.DATA_W(DATA_W)) u_rd (
    .clk   (clk),
    .rst_n (rst_n_int),
    .rd_en (rd_en),
    .sel   (sel),
    .level (pin_level),
    .dir   (pin_dir),
    .aux   (aux_word),
    .rdata (bus_rdata),
    .rvld  (bus_rvld)
  );

  // Bad-access pulse: unknown write target or a set/clear turned away
  always_comb begin
    bad_d = (wr_en & ~sel.known) | reject;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      bad_q <= 1'b0;
    end else begin
      bad_q <= bad_d;
    end
  end

  assign bad_access = bad_q;
  assign irq_lines  = '0;

endmodule

// File: rtl/gpio_regblk_chk.sv
module gpio_regblk_chk
  import gpio_regblk_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int N_IRQ  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_vld,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rvld,
  input logic              bad_access,
  input logic [DATA_W-1:0] pin_level,
  input logic [DATA_W-1:0] pin_dir,
  input logic [N_IRQ-1:0]  irq_lines
);

  logic wr_set, wr_clr, wr_dir, gated_ok, pin_write;

  always_comb begin
    wr_set    = bus_vld && bus_wr && (bus_addr == OFF_SET[ADDR_W-1:0]);
    wr_clr    = bus_vld && bus_wr && (bus_addr == OFF_CLR[ADDR_W-1:0]);
    wr_dir    = bus_vld && bus_wr && (bus_addr == OFF_DIR[ADDR_W-1:0]);
    gated_ok  = (bus_wdata & pin_dir) != '0;
    pin_write = wr_set || wr_clr;
  end

  assert_irq_idle_R11: assert property (@(posedge clk) irq_lines == '0);

  assert_rvld_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && !bus_wr) |=> bus_rvld);

  assert_rvld_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_vld && !bus_wr) |=> !bus_rvld);

  assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> pin_dir == $past(bus_wdata));

  assert_set_apply_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set && gated_ok) |=> pin_level == ($past(pin_level) | $past(bus_wdata)));

  assert_clr_apply_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && gated_ok) |=> pin_level == ($past(pin_level) & ~$past(bus_wdata)));

  assert_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_write && !gated_ok) |=> ($stable(pin_level) && bad_access));

  assert_level_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_write |=> $stable(pin_level));

  assert_bad_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> $past(bus_vld && bus_wr));

endmodule

bind gpio_regblk gpio_regblk_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .N_IRQ  (N_IRQ)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_vld    (bus_vld),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rvld   (bus_rvld),
  .bad_access (bad_access),
  .pin_level  (pin_level),
  .pin_dir    (pin_dir),
  .irq_lines  (irq_lines)
);

// File: tb/sim_gpio_regblk.sv
module sim_gpio_regblk;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int N_IRQ  = 9;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] exp_rd;
    logic              exp_bad;
    logic [7:0]        req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'h04, 32'h0000_00FF, 32'h0,          1'b0, 8'd2},  // R2 direction load
    '{1'b0, 6'h04, 32'h0,         32'h0000_00FF, 1'b0, 8'd2},  // R2 direction readback
    '{1'b1, 6'h08, 32'h0000_0F0F, 32'h0,          1'b0, 8'd4},  // R4 set accepted
    '{1'b0, 6'h00, 32'h0,         32'h0000_0F0F, 1'b0, 8'd4},  // R4 whole value applied
    '{1'b1, 6'h08, 32'hFFFF_0000, 32'h0,          1'b1, 8'd6},  // R6 set rejected
    '{1'b0, 6'h00, 32'h0,         32'h0000_0F0F, 1'b0, 8'd6},  // R6 level kept
    '{1'b1, 6'h0C, 32'h0000_0101, 32'h0,          1'b0, 8'd5},  // R5 clear accepted
    '{1'b0, 6'h00, 32'h0,         32'h0000_0E0E, 1'b0, 8'd5},  // R5 readback
    '{1'b1, 6'h0C, 32'h0000_0E00, 32'h0,          1'b1, 8'd6},  // R6 clear rejected
    '{1'b0, 6'h00, 32'h0,         32'h0000_0E0E, 1'b0, 8'd6},  // R6 level kept
    '{1'b1, 6'h0C, 32'h0000_0E02, 32'h0,          1'b0, 8'd5},  // R5 overlap clears all
    '{1'b0, 6'h00, 32'h0,         32'h0000_000C, 1'b0, 8'd5},  // R5 readback
    '{1'b1, 6'h10, 32'hFFFF_FFFF, 32'h0,          1'b0, 8'd7},  // R7 rise cfg ignored
    '{1'b1, 6'h14, 32'hFFFF_FFFF, 32'h0,          1'b0, 8'd7},  // R7 fall cfg ignored
    '{1'b1, 6'h18, 32'hFFFF_FFFF, 32'h0,          1'b0, 8'd7},  // R7 status ignored
    '{1'b0, 6'h00, 32'h0,         32'h0000_000C, 1'b0, 8'd7},  // R7 level intact
    '{1'b0, 6'h04, 32'h0,         32'h0000_00FF, 1'b0, 8'd7},  // R7 direction intact
    '{1'b0, 6'h10, 32'h0,         32'h0,          1'b0, 8'd8},  // R8 edge cfg reads zero
    '{1'b0, 6'h08, 32'h0,         32'h0,          1'b0, 8'd8},  // R8 set port reads zero
    '{1'b1, 6'h20, 32'hDEAD_BEEF, 32'h0,          1'b0, 8'd2},  // R2 aux load
    '{1'b0, 6'h20, 32'h0,         32'hDEAD_BEEF, 1'b0, 8'd2},  // R2 aux readback
    '{1'b1, 6'h24, 32'hFFFF_FFFF, 32'h0,          1'b1, 8'd9},  // R9 undecoded write
    '{1'b1, 6'h1C, 32'hFFFF_FFFF, 32'h0,          1'b1, 8'd9},  // R9 gap offset
    '{1'b1, 6'h0A, 32'hFFFF_FFFF, 32'h0,          1'b1, 8'd9},  // R9 misaligned write
    '{1'b0, 6'h24, 32'h0,         32'h0,          1'b0, 8'd8},  // R8 undecoded read
    '{1'b0, 6'h20, 32'h0,         32'hDEAD_BEEF, 1'b0, 8'd9},  // R9 aux intact
    '{1'b1, 6'h04, 32'hFFFF_0000, 32'h0,          1'b0, 8'd10}, // R10 direction change
    '{1'b0, 6'h00, 32'h0,         32'h0000_000C, 1'b0, 8'd10}, // R10 level unchanged
    '{1'b1, 6'h08, 32'h8000_0000, 32'h0,          1'b0, 8'd4},  // R4 new output bit
    '{1'b0, 6'h00, 32'h0,         32'h8000_000C, 1'b0, 8'd4}   // R4 readback
  };

  logic              clk;
  logic              rst_n;
  logic              bus_vld;
  logic              bus_wr;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              bus_rvld;
  logic              bad_access;
  logic [DATA_W-1:0] pin_level;
  logic [DATA_W-1:0] pin_dir;
  logic [N_IRQ-1:0]  irq_lines;

  int checks;
  int errors;
  bit done;

  gpio_regblk u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_vld    (bus_vld),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvld   (bus_rvld),
    .bad_access (bad_access),
    .pin_level  (pin_level),
    .pin_dir    (pin_dir),
    .irq_lines  (irq_lines)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Drive one request for one cycle, then sample on the following falling edge
  task automatic bus_op(input vec_t v);
    @(negedge clk);
    bus_vld   = 1'b1;
    bus_wr    = v.wr;
    bus_addr  = v.addr;
    bus_wdata = v.wdata;
    @(negedge clk);
    bus_vld   = 1'b0;
    bus_wr    = 1'b0;
    bus_wdata = '0;
    check($sformatf("R%0d bad_access", v.req), {31'b0, bad_access}, {31'b0, v.exp_bad});
    check("R3 rvld", {31'b0, bus_rvld}, {31'b0, ~v.wr});
    check("R11 irq", {23'b0, irq_lines}, '0);
    if (!v.wr) check($sformatf("R%0d rdata @0x%02h", v.req, v.addr), bus_rdata, v.exp_rd);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; bus_vld = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1 level", pin_level, '0);
    check("R1 dir", pin_dir, '0);
    check("R1 rvld", {31'b0, bus_rvld}, '0);
    check("R1 bad", {31'b0, bad_access}, '0);
    check("R1 rdata", bus_rdata, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_op('{1'b0, 6'h20, 32'h0, 32'h0, 1'b0, 8'd1});  // R1 aux zero after reset
    bus_op('{1'b0, 6'h00, 32'h0, 32'h0, 1'b0, 8'd1});  // R1 level zero after reset

    for (int i = 0; i < NV; i++) bus_op(VECS[i]);

    // R3: idle cycle drops rvld
    @(negedge clk);
    check("R3 idle rvld", {31'b0, bus_rvld}, '0);

    // R6: with direction all zero every set is turned away
    bus_op('{1'b1, 6'h04, 32'h0,         32'h0, 1'b0, 8'd2});
    bus_op('{1'b1, 6'h08, 32'hFFFF_FFFF, 32'h0, 1'b1, 8'd6});
    check("R6 level after all-ones set", pin_level, 32'h8000_000C);

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid level", pin_level, '0);
    check("R1 mid dir", pin_dir, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_op('{1'b0, 6'h20, 32'h0, 32'h0, 1'b0, 8'd1});  // R1 aux cleared

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule